// File: doc/BRIEF.md
# PWM Timer with One-Shot Mode

This block is a general-purpose pulse timer for a peripheral subsystem. Software programs a period and a high-time (width) through a small register write port, then enables the timer. The timer drives one output pin. In continuous mode the pin repeats a rectangular wave. In one-shot mode the pin carries a single pulse, and then the timer turns itself off. One-shot mode can also serve as a timed software delay. The internal count advances once every two clock cycles, so every duration is an even number of clock cycles.

A new period or width can be written while the timer runs. Such values are only staged. A width write marks the staged pair as committed, and the committed pair moves into the running counter at the next period boundary. Software must therefore always write the width last, and must rewrite the width even when only the period changes. An interrupt latch reports period ends and one-shot completion. The latch stays set until software clears it. A sticky error flag reports attempts to run with unusable values.

Top module: `pwm_oneshot_timer`

## Requirements
- R1: After reset, `running`, `irq` and `err` are 0, and `pwm_out` is 1, because the polarity bit resets to 0 (active low).
- R2: Control bit 1 selects the polarity. When it is 1 the active level is high, and when it is 0 the active level is low. A change takes effect on `pwm_out` in the cycle after the write, even while the timer is running.
- R3: The control register is at `wr_sel`=0 and has these fields: bit0 enable, bit1 polarity, bit2 continuous mode, bit3 interrupt enable, bit4 error clear (write one to clear). The period is at `wr_sel`=1 and the width is at `wr_sel`=2, each in the low 31 bits of the write data. If enable is written to 1 while the timer is stopped and the staged values are valid, the timer loads them and starts counting from zero with the output active.
- R4: In continuous mode, each period keeps the output active for 2×width clock cycles and then inactive for 2×(period−width) clock cycles, and the pattern repeats.
- R5: In continuous mode with interrupts enabled, `irq` is set at the end of every period. It stays set until a cycle with `irq_clr` high. If a set and a clear fall in the same cycle, the set wins.
- R6: Period and width writes made while the timer runs do not change the waveform until a width write has been made. After that, they take effect at the next period end.
- R7: In one-shot mode (bit2 = 0), the output is active for 2×width clock cycles. The timer then clears `running` and sets `irq`, even when interrupts are disabled.
- R8: Values are invalid if the period is below 2, the width is 0, or the width is not less than the period. A start with invalid values sets `err` and does not run. A committed invalid pair reaching a period end sets `err`, and the timer keeps its previous values. `err` stays set until a control write with bit4 set.
- R9: Writing enable as 0 stops the timer at once, and the output goes to its inactive level.
- R10: With period 2 and width 1, the output toggles every 2 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 width |
| wr_data | input | 32 | Write data |
| irq_clr | input | 1 | Clears the interrupt latch |
| pwm_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt latch |
| err | output | 1 | Sticky invalid-setting flag |
| running | output | 1 | Enable status; reads 0 after a one-shot completes |

## Verification
The hardest case to reach is a committed update that lands exactly on a period boundary. Two variants matter: the committed pair is invalid, and the period is rewritten without a following width write. The stimulus produces both. It starts a short continuous wave, writes only a period and leaves the timer running for several periods, and then adds the width write. Later it commits a width larger than the period while the wave keeps running. A behavioural model updates every clock and follows each staged value through to the reload, so a reload that happens one period early or late is caught.

// File: rtl/pwm_oneshot_timer.sv
module pwm_oneshot_timer #(
  parameter int CNT_W  = 31,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_clr,
  output logic              pwm_out,
  output logic              irq,
  output logic              err,
  output logic              running
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PRD  = 2'd1;
  localparam logic [1:0] SEL_WID  = 2'd2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] prd_stg, wid_stg, prd_act, wid_act, cnt;
  logic pend, ph, pol, cont, ien;

  wire ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  wire prd_wr    = wr_en && (wr_sel == SEL_PRD);
  wire wid_wr    = wr_en && (wr_sel == SEL_WID);
  wire stg_ok    = (prd_stg >= TWO) && (wid_stg != '0) && (wid_stg < prd_stg);
  wire start     = ctrl_wr && wr_data[0] && !running;
  wire stop      = ctrl_wr && !wr_data[0];
  wire tick      = running && ph && !stop;
  wire pulse_end = tick && !cont && (cnt == wid_act - ONE);
  wire prd_end   = tick && cont && (cnt == prd_act - ONE);
  wire reload    = prd_end && pend;
  wire load_act  = (start || reload) && stg_ok;

  assign pwm_out = (running && (cnt < wid_act)) ? pol : !pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prd_stg <= '0;
      wid_stg <= '0;
      prd_act <= '0;
      wid_act <= '0;
      cnt     <= '0;
      ph      <= 1'b0;
      pend    <= 1'b0;
      pol     <= 1'b0;
      cont    <= 1'b0;
      ien     <= 1'b0;
      running <= 1'b0;
      irq     <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        pol  <= wr_data[1];
        cont <= wr_data[2];
        ien  <= wr_data[3];
      end
      if (prd_wr) prd_stg <= wr_data[CNT_W-1:0];
      if (wid_wr) wid_stg <= wr_data[CNT_W-1:0];

      if (wid_wr)                 pend <= 1'b1;
      else if (start || prd_end)  pend <= 1'b0;

      if ((start || reload) && !stg_ok)  err <= 1'b1;
      else if (ctrl_wr && wr_data[4])    err <= 1'b0;

      if (load_act) begin
        prd_act <= prd_stg;
        wid_act <= wid_stg;
      end

      if (start && stg_ok)           running <= 1'b1;
      else if (stop || pulse_end)    running <= 1'b0;

      if (start) begin
        cnt <= '0;
        ph  <= 1'b0;
      end else if (running && !stop) begin
        ph <= !ph;
        if (tick) cnt <= prd_end ? '0 : cnt + ONE;
      end

      if (pulse_end || (prd_end && ien)) irq <= 1'b1;
      else if (irq_clr)                  irq <= 1'b0;
    end
  end

  AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (pwm_out == !pol));  // R9
  AST_ACT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ((prd_act >= TWO) && (wid_act != '0) && (wid_act < prd_act)));  // R8
  AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < prd_act));  // R4
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);  // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(ctrl_wr && wr_data[4])) |=> err);  // R8
  AST_SHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !cont && ph && (cnt == wid_act - ONE) && !ctrl_wr) |=> (!running && irq));  // R7
  AST_ACT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(ph && cont && (cnt == prd_act - ONE))) |=> ($stable(prd_act) && $stable(wid_act)));  // R6
endmodule

// File: tb/pwm_oneshot_timer_tb.sv
module pwm_oneshot_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic irq_clr = 1'b0;
  logic pwm_out, irq, err, running;

  pwm_oneshot_timer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .irq_clr(irq_clr), .pwm_out(pwm_out), .irq(irq), .err(err), .running(running)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  longint m_sp = 0, m_sw = 0, m_p = 0, m_w = 0, m_t = 0;
  bit m_pend = 0, m_run = 0, m_pol = 0, m_cont = 0, m_ien = 0, m_irq = 0, m_err = 0;

  function automatic bit ok_vals(longint p, longint w);
    return (p >= 2) && (w != 0) && (w < p);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sp = 0; m_sw = 0; m_p = 0; m_w = 0; m_t = 0;
      m_pend = 0; m_run = 0; m_pol = 0; m_cont = 0; m_ien = 0; m_irq = 0; m_err = 0;
    end else begin
      bit set_irq, clr_done, ctrl, start, stop;
      set_irq = 0;
      ctrl  = wr_en && wr_sel == 2'd0;
      start = ctrl && wr_data[0] && !m_run;
      stop  = ctrl && !wr_data[0];
      if (ctrl && wr_data[4]) m_err = 0;
      if (start) begin
        if (ok_vals(m_sp, m_sw)) begin
          m_run = 1; m_t = 0; m_p = m_sp; m_w = m_sw;
        end else m_err = 1;
        m_pend = 0;
      end else if (stop) begin
        m_run = 0;
      end else if (m_run) begin
        if (!m_cont && m_t == 2*m_w - 1) begin
          m_run = 0; set_irq = 1;
        end else if (m_cont && m_t == 2*m_p - 1) begin
          m_t = 0;
          if (m_ien) set_irq = 1;
          if (m_pend) begin
            m_pend = 0;
            if (ok_vals(m_sp, m_sw)) begin m_p = m_sp; m_w = m_sw; end
            else m_err = 1;
          end
        end else m_t++;
      end
      if (ctrl) begin m_pol = wr_data[1]; m_cont = wr_data[2]; m_ien = wr_data[3]; end
      if (wr_en && wr_sel == 2'd1) m_sp = longint'(wr_data[30:0]);
      if (wr_en && wr_sel == 2'd2) begin m_sw = longint'(wr_data[30:0]); m_pend = 1; end
      clr_done = irq_clr;
      if (set_irq) m_irq = 1;
      else if (clr_done) m_irq = 0;
    end
  end

  task automatic cmp(string what, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: got %b expected %b", cur_req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("pwm_out", pwm_out, (m_run && m_t < 2*m_w) ? m_pol : !m_pol);
      cmp("irq", irq, m_irq);
      cmp("err", err, m_err);
      cmp("running", running, m_run);
    end
  end

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulse_clr;
    @(posedge clk); #2; irq_clr = 1'b1;
    @(posedge clk); #2; irq_clr = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    #1;
    cur_req = "R1";
    cmp("reset pwm_out", pwm_out, 1'b1);
    cmp("reset running", running, 1'b0);
    idle(3); #1 rst_n = 1'b1;
    idle(4);

    cur_req = "R3";
    wr(2'd1, 32'd5); wr(2'd2, 32'd2);
    wr(2'd0, 32'b01111);
    cur_req = "R4";
    idle(30);
    cur_req = "R5";
    pulse_clr(); idle(25); pulse_clr();

    cur_req = "R6";
    wr(2'd1, 32'd7);
    idle(40);
    wr(2'd2, 32'd3);
    idle(40);

    cur_req = "R2";
    wr(2'd0, 32'b01101);
    idle(30);

    cur_req = "R9";
    wr(2'd0, 32'b00000);
    idle(10);

    cur_req = "R10";
    wr(2'd1, 32'd2); wr(2'd2, 32'd1);
    wr(2'd0, 32'b00111);
    idle(20);
    wr(2'd0, 32'd0);

    cur_req = "R8";
    wr(2'd1, 32'd1); wr(2'd2, 32'd1);
    wr(2'd0, 32'b00111);
    idle(6);
    wr(2'd0, 32'b10000);
    wr(2'd1, 32'd3); wr(2'd2, 32'd3);
    wr(2'd0, 32'b00111);
    idle(4);
    wr(2'd0, 32'b10000);
    wr(2'd1, 32'd4); wr(2'd2, 32'd1);
    wr(2'd0, 32'b00111);
    idle(5);
    wr(2'd1, 32'd3); wr(2'd2, 32'd5);
    idle(30);
    wr(2'd0, 32'b10110);
    idle(10);
    wr(2'd0, 32'd0);

    cur_req = "R7";
    pulse_clr();
    wr(2'd1, 32'd6); wr(2'd2, 32'd3);
    wr(2'd0, 32'b00011);
    idle(20);
    pulse_clr();
    wr(2'd0, 32'b01001);
    idle(20);
    cmp("one-shot done running", running, 1'b0);

    finish_run();
  end
endmodule